// File: doc/BRIEF.md
# Register Readiness Scoreboard with Operand Forwarding

This block keeps track of which architectural registers still await a result in a five-stage in-order pipeline. It sits beside the decode and register-read stage. Each register has one busy bit. Decode raises the bit for its destination when it issues a writer. Write-back lowers the bit again, unless a younger writer of the same register is still in flight. A flush lowers the bit for a writer that it squashes in the execute stage.

For each source operand in decode, the block picks where the operand value comes from: the register file, or a result carried back from the execute, memory or write-back stage. When several in-flight writers target the same register, it picks the youngest one. Only a load in execute that feeds a source in decode holds decode back. During that held cycle the block asks for one bubble in the execute buffer and raises a read-pending flag for the register. On the next cycle the operand is taken from the memory stage. A parameter can instead build a plain busy-bit variant, in which any busy source stalls decode and every operand reads the register file.

Top module: `reg_scoreboard`

## Requirements
- R1: When decode issues an instruction (`dec_valid` high, `stall` low, `flush` low) with `dec_wen` high and a nonzero `dec_rd`, bit `dec_rd` of `busy_vec` reads 1 in the next cycle.
- R2: A write-back of register r (`wb_valid` and `wb_wen`) lowers `busy_vec[r]` at the next edge only when no unsquashed writer of r remains in execute or memory. If decode issues a new writer of r in the same cycle, the bit stays set.
- R3: Register 0 is never marked busy. A source field of 0 never causes a stall, and its select reads the register file (code 0).
- R4: In forwarding mode, `stall` and `bubble` are high in a cycle exactly when a source in decode names the destination of a valid load writer in execute (and no flush is present). A held instruction does not mark its destination busy.
- R5: A non-load writer in execute whose destination is a source in decode causes no stall, and that source selects the execute result.
- R6: Each source has a 2-bit select: 0 = register file, 1 = execute, 2 = memory, 3 = write-back. When several stages hold writers of that source, the youngest one is chosen (execute before memory before write-back).
- R7: A source register that held decode has its `pend_vec` bit set in the cycle after the hold. In that cycle the operand selects the memory-stage value (code 2) and `stall` is low.
- R8: `flush` forces `stall` and `bubble` low and clears every `pend_vec` bit at the next edge. It clears the busy bit of a writer in execute unless a writer of the same register sits in memory.
- R9: A source whose register is neither busy nor read-pending selects the register file, and does not stall.
- R10: `bubble` is high in exactly the cycles in which `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Squash decode and execute contents |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_src | input | NSRC*AW | Source register numbers, source i at bits [i*AW +: AW] |
| dec_rd | input | AW | Destination register of the decode instruction |
| dec_wen | input | 1 | Decode instruction writes a register |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rd | input | AW | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_rd | input | AW | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_rd | input | AW | Write-back destination |
| wb_wen | input | 1 | Write-back instruction writes a register |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Insert a no-op into the execute buffer |
| fwd_sel | output | 2*NSRC | Per-source operand select, source i at bits [2*i +: 2] |
| busy_vec | output | NREG | Busy bit of every register |
| pend_vec | output | NREG | Read-pending flag of every register |

## Verification
The bench builds the block with eight registers, two sources and forwarding enabled. With eight registers it can sweep every register number, including register 0, against every producer-to-consumer distance from one to four and both load and non-load producers. The bench drives its own three-stage pipeline model from the `stall` and `flush` ports. Directed sequences then cover the youngest-writer choice, a set and a clear in the same cycle, and flushes that land either on the load in execute or on a held consumer.

// File: rtl/regsb_pkg.sv
`timescale 1ns/1ps
package regsb_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_EX  = 2'd1,
      SEL_MEM = 2'd2,
      SEL_WB  = 2'd3
   } opsel_e;
endpackage

// File: rtl/regsb_busy.sv
`timescale 1ns/1ps
module regsb_busy #(
   parameter int NREG = 32,
   parameter int AW   = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue,
   input  logic            dec_wen,
   input  logic [AW-1:0]   dec_rd,
   input  logic            flush,
   input  logic            ex_valid,
   input  logic            ex_wen,
   input  logic [AW-1:0]   ex_rd,
   input  logic            mem_valid,
   input  logic            mem_wen,
   input  logic [AW-1:0]   mem_rd,
   input  logic            wb_valid,
   input  logic            wb_wen,
   input  logic [AW-1:0]   wb_rd,
   output logic [NREG-1:0] busy
);
   // register 0 is hard-wired ready
   assign busy[0] = 1'b0;

   for (genvar r = 1; r < NREG; r++) begin : g_reg
      logic set_r, live_r, drop_r, bit_q;
      always_comb begin
         set_r  = issue & dec_wen & (dec_rd == AW'(r));
         live_r = (ex_valid & ex_wen & ~flush & (ex_rd == AW'(r)))
                | (mem_valid & mem_wen & (mem_rd == AW'(r)));
         drop_r = (wb_valid & wb_wen & (wb_rd == AW'(r)))
                | (flush & ex_valid & ex_wen & (ex_rd == AW'(r)));
      end
      always_ff @(posedge clk) begin
         if (!rst_n)                bit_q <= 1'b0;
         else if (set_r)            bit_q <= 1'b1;
         else if (drop_r & ~live_r) bit_q <= 1'b0;
      end
      assign busy[r] = bit_q;
   end

   assert_issue_marks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && dec_wen && dec_rd != '0) |=> busy[$past(dec_rd)]);

   assert_wb_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_wen && wb_rd != '0
       && !(issue && dec_wen && dec_rd == wb_rd)
       && !(ex_valid && ex_wen && !flush && ex_rd == wb_rd)
       && !(mem_valid && mem_wen && mem_rd == wb_rd)) |=> !busy[$past(wb_rd)]);
endmodule

// File: rtl/regsb_pend.sv
`timescale 1ns/1ps
module regsb_pend #(
   parameter int NREG = 32,
   parameter int NSRC = 2,
   parameter int AW   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [NSRC-1:0]   hold_hit,
   input  logic [NSRC*AW-1:0] src,
   output logic [NREG-1:0]   pend
);
   logic [NREG-1:0] pend_d;

   always_comb begin
      pend_d = '0;
      if (!flush) begin
         for (int i = 0; i < NSRC; i++) begin
            if (hold_hit[i]) pend_d[src[i*AW +: AW]] = 1'b1;
         end
      end
      pend_d[0] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_d;
   end

   assert_pend_follows_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend) |-> $past(|hold_hit));

   assert_flush_drops_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pend == '0));
endmodule

// File: rtl/regsb_opsel.sv
`timescale 1ns/1ps
module regsb_opsel
   import regsb_pkg::*;
#(
   parameter int NREG    = 32,
   parameter int AW      = $clog2(NREG),
   parameter bit FORWARD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   src,
   input  logic [NREG-1:0] busy,
   input  logic [NREG-1:0] pend,
   input  logic            ex_valid,
   input  logic            ex_wen,
   input  logic [AW-1:0]   ex_rd,
   input  logic            ex_is_load,
   input  logic            mem_valid,
   input  logic            mem_wen,
   input  logic [AW-1:0]   mem_rd,
   input  logic            wb_valid,
   input  logic            wb_wen,
   input  logic [AW-1:0]   wb_rd,
   output opsel_e          sel,
   output logic            hazard
);
   logic nonzero, tracked;
   assign nonzero = (src != '0);
   assign tracked = nonzero & (busy[src] | pend[src]);

   if (FORWARD) begin : g_fwd
      logic ex_m, mem_m, wb_m;
      assign ex_m  = ex_valid  & ex_wen  & (ex_rd  == src);
      assign mem_m = mem_valid & mem_wen & (mem_rd == src);
      assign wb_m  = wb_valid  & wb_wen  & (wb_rd  == src);
      always_comb begin
         sel    = SEL_RF;
         hazard = 1'b0;
         if (tracked) begin
            if (ex_m) begin
               hazard = ex_is_load;
               sel    = ex_is_load ? SEL_RF : SEL_EX;
            end else if (mem_m) begin
               sel = SEL_MEM;
            end else if (wb_m) begin
               sel = SEL_WB;
            end
         end
      end
   end else begin : g_plain
      logic unused_fwd;
      assign unused_fwd = ^{ex_valid, ex_wen, ex_rd, ex_is_load, mem_valid,
                            mem_wen, mem_rd, wb_valid, wb_wen, wb_rd, pend};
      assign sel    = SEL_RF;
      assign hazard = nonzero & busy[src];
   end

   assert_zero_src_rf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |-> (sel == SEL_RF && !hazard));

   assert_fwd_needs_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != SEL_RF) |-> (busy[src] || pend[src]));
endmodule

// File: rtl/reg_scoreboard.sv
`timescale 1ns/1ps
module reg_scoreboard
   import regsb_pkg::*;
#(
   parameter int NREG    = 32,
   parameter int NSRC    = 2,
   parameter bit FORWARD = 1'b1,
   localparam int AW     = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 dec_valid,
   input  logic [NSRC*AW-1:0]   dec_src,
   input  logic [AW-1:0]        dec_rd,
   input  logic                 dec_wen,
   input  logic                 ex_valid,
   input  logic [AW-1:0]        ex_rd,
   input  logic                 ex_wen,
   input  logic                 ex_is_load,
   input  logic                 mem_valid,
   input  logic [AW-1:0]        mem_rd,
   input  logic                 mem_wen,
   input  logic                 wb_valid,
   input  logic [AW-1:0]        wb_rd,
   input  logic                 wb_wen,
   output logic                 stall,
   output logic                 bubble,
   output logic [2*NSRC-1:0]    fwd_sel,
   output logic [NREG-1:0]      busy_vec,
   output logic [NREG-1:0]      pend_vec
);
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("reg_scoreboard: NREG must be a power of two of at least 2");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("reg_scoreboard: NSRC must be at least 1");
   end

   logic [NSRC-1:0] hazard_w;
   logic [NSRC-1:0] hold_hit;
   logic            issue;

   assign stall    = dec_valid & ~flush & (|hazard_w);
   assign bubble   = stall;
   assign issue    = dec_valid & ~stall & ~flush;
   assign hold_hit = stall ? hazard_w : '0;

   regsb_busy #(.NREG(NREG), .AW(AW)) u_busy (
      .clk(clk), .rst_n(rst_n), .issue(issue), .dec_wen(dec_wen), .dec_rd(dec_rd),
      .flush(flush), .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_rd(ex_rd),
      .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
      .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd), .busy(busy_vec));

   regsb_pend #(.NREG(NREG), .NSRC(NSRC), .AW(AW)) u_pend (
      .clk(clk), .rst_n(rst_n), .flush(flush), .hold_hit(hold_hit),
      .src(dec_src), .pend(pend_vec));

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      opsel_e sel_i;
      regsb_opsel #(.NREG(NREG), .AW(AW), .FORWARD(FORWARD)) u_sel (
         .clk(clk), .rst_n(rst_n), .src(dec_src[i*AW +: AW]),
         .busy(busy_vec), .pend(pend_vec),
         .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
         .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
         .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd),
         .sel(sel_i), .hazard(hazard_w[i]));
      assign fwd_sel[2*i +: 2] = sel_i;
   end

   assert_hold_yields_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !stall);

   assert_held_no_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && dec_wen && dec_rd != '0 && !busy_vec[dec_rd]) |=> !busy_vec[$past(dec_rd)]);

   assert_zero_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_vec[0] && !pend_vec[0]);
endmodule

// File: tb/tb_reg_scoreboard.sv
`timescale 1ns/1ps
module tb_reg_scoreboard;
   localparam int NREG = 8;
   localparam int NSRC = 2;
   localparam int AW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            flush = 1'b0;
   logic            dec_valid = 1'b0;
   logic [NSRC*AW-1:0] dec_src = '0;
   logic [AW-1:0]   dec_rd = '0;
   logic            dec_wen = 1'b0;
   logic            dec_ld = 1'b0;
   logic            ex_v, ex_w, ex_l, mem_v, mem_w, wb_v, wb_w;
   logic [AW-1:0]   ex_r, mem_r, wb_r;
   logic            stall, bubble;
   logic [2*NSRC-1:0] fwd_sel;
   logic [NREG-1:0] busy_vec, pend_vec;

   int n_run = 0;
   int n_fail = 0;

   reg_scoreboard #(.NREG(NREG), .NSRC(NSRC), .FORWARD(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .dec_valid(dec_valid),
      .dec_src(dec_src), .dec_rd(dec_rd), .dec_wen(dec_wen),
      .ex_valid(ex_v), .ex_rd(ex_r), .ex_wen(ex_w), .ex_is_load(ex_l),
      .mem_valid(mem_v), .mem_rd(mem_r), .mem_wen(mem_w),
      .wb_valid(wb_v), .wb_rd(wb_r), .wb_wen(wb_w),
      .stall(stall), .bubble(bubble), .fwd_sel(fwd_sel),
      .busy_vec(busy_vec), .pend_vec(pend_vec));

   // pipeline model driven by the block's stall and flush ports
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_v <= 0; ex_w <= 0; ex_l <= 0; ex_r <= '0;
         mem_v <= 0; mem_w <= 0; mem_r <= '0;
         wb_v <= 0; wb_w <= 0; wb_r <= '0;
      end else begin
         wb_v <= mem_v; wb_w <= mem_w; wb_r <= mem_r;
         mem_v <= ex_v & ~flush; mem_w <= ex_w; mem_r <= ex_r;
         ex_v <= dec_valid & ~stall & ~flush;
         ex_w <= dec_wen; ex_r <= dec_rd; ex_l <= dec_ld;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic adv;
      @(posedge clk); #1;
   endtask

   task automatic look;
      @(negedge clk);
   endtask

   task automatic drv(input logic v, input int s0, input int s1, input int rd,
                      input logic w, input logic ld);
      dec_valid = v;
      dec_src   = {AW'(s1), AW'(s0)};
      dec_rd    = AW'(rd);
      dec_wen   = w;
      dec_ld    = ld;
   endtask

   task automatic drain;
      for (int k = 0; k < 4; k++) begin
         adv; drv(0, 0, 0, 0, 0, 0); look;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      drv(0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      look;
      chk("R1 reset busy", int'(busy_vec), 0);
      chk("R7 reset pend", int'(pend_vec), 0);
      chk("R10 reset stall", int'(stall), 0);

      // sweep: register x distance x load flag
      for (int r = 0; r < NREG; r++) begin
         for (int d = 1; d <= 4; d++) begin
            for (int ld = 0; ld < 2; ld++) begin
               drain;
               adv; drv(1, 0, 0, r, 1, ld[0]); look;
               chk("R9 producer no stall", int'(stall), 0);
               adv;
               for (int k = 1; k < d; k++) begin
                  drv(1, 0, 0, 0, 0, 0); look; adv;
               end
               drv(1, r, 0, 0, 0, 0); look;
               chk("R1 busy at consumer", int'(busy_vec[r]), (r != 0 && d <= 3) ? 1 : 0);
               if (r == 0) begin
                  chk("R3 zero no stall", int'(stall), 0);
                  chk("R3 zero sel rf", int'(fwd_sel[1:0]), 0);
               end else if (d == 1 && ld == 1) begin
                  chk("R4 load use stall", int'(stall), 1);
                  chk("R10 bubble", int'(bubble), 1);
                  adv; look;
                  chk("R4 one bubble only", int'(stall), 0);
                  chk("R7 pend raised", int'(pend_vec[r]), 1);
                  chk("R7 sel mem", int'(fwd_sel[1:0]), 2);
               end else begin
                  chk("R5 no stall", int'(stall), 0);
                  chk("R6 sel by distance", int'(fwd_sel[1:0]), (d == 4) ? 0 : d);
                  chk("R9 src1 zero rf", int'(fwd_sel[3:2]), 0);
               end
            end
         end
      end

      // R6 youngest writer wins, R2 older write-back keeps bit
      drain;
      adv; drv(1, 0, 0, 3, 1, 0); look;
      adv; drv(1, 0, 0, 3, 1, 0); look;
      adv; drv(1, 0, 3, 0, 0, 0); look;
      chk("R6 youngest ex over mem", int'(fwd_sel[3:2]), 1);
      adv; drv(1, 3, 0, 0, 0, 0); look;
      chk("R6 youngest mem over wb", int'(fwd_sel[1:0]), 2);
      adv; drv(0, 0, 0, 0, 0, 0); look;
      chk("R2 busy kept by younger", int'(busy_vec[3]), 1);
      adv; look;
      chk("R2 busy released", int'(busy_vec[3]), 0);

      // R2 set wins over same-cycle clear
      drain;
      adv; drv(1, 0, 0, 5, 1, 0); look;
      adv; drv(1, 0, 0, 0, 0, 0); look;
      adv; drv(1, 0, 0, 0, 0, 0); look;
      adv; drv(1, 0, 0, 5, 1, 0); look;
      adv; drv(0, 0, 0, 0, 0, 0); look;
      chk("R2 set beats clear", int'(busy_vec[5]), 1);

      // R8 flush squashes the load in execute
      drain;
      adv; drv(1, 0, 0, 6, 1, 1); look;
      adv; drv(1, 6, 0, 0, 0, 0); flush = 1'b1; look;
      chk("R8 flush no stall", int'(stall), 0);
      chk("R10 flush no bubble", int'(bubble), 0);
      adv; flush = 1'b0; drv(0, 0, 0, 0, 0, 0); look;
      chk("R8 squashed busy clear", int'(busy_vec[6]), 0);
      chk("R8 pend clear", int'(pend_vec), 0);

      // R8 flush on a held consumer keeps the older load's bit
      drain;
      adv; drv(1, 0, 0, 6, 1, 1); look;
      adv; drv(1, 0, 6, 0, 0, 0); look;
      chk("R4 src1 load use stall", int'(stall), 1);
      adv; flush = 1'b1; look;
      chk("R7 pend on src1", int'(pend_vec[6]), 1);
      chk("R8 stall low in flush", int'(stall), 0);
      adv; flush = 1'b0; drv(0, 0, 0, 0, 0, 0); look;
      chk("R8 pend cleared", int'(pend_vec), 0);
      chk("R8 older writer kept", int'(busy_vec[6]), 1);
      drain;
      chk("R2 all released", int'(busy_vec), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule